// File: doc/BRIEF.md
# Differential Eight-Phase Tribit Codec

This block turns a serial, already scrambled bit stream into a sequence of absolute carrier phase indices, and turns received phase indices back into bits. On the transmit side, bits arrive one per bit strobe and are packed into groups of three. On each symbol strobe, the most recently completed group is mapped through a fixed, non-binary table to a phase increment in 45-degree steps. That increment is added, modulo 8, to a 3-bit phase accumulator. The information therefore sits in the change of phase between successive signal elements, not in the phase itself.

The receive side keeps the previous received phase index. On each receive symbol strobe it takes the modulo-8 difference to the previous index and applies the inverse table to recover the group. It then hands the three bits out serially, earliest bit first, on request strobes. A training input makes every transmitted symbol a half-turn (index +4) regardless of the data, as used for receiver conditioning. At three bit strobes per symbol strobe, the intended rates are 4800 bit/s and 1600 symbols/s. Carrier generation and spectral shaping belong to downstream blocks.

Top module: `dpsk8_codec`

## Requirements
- R1: After reset, tx_phase is 0, rx_tribit_valid and rx_bit_valid are 0, and a partly assembled group is discarded, so the next three bits form a fresh group.
- R2: The bit taken on the first of three tx_bit_en strobes becomes bit 2 (leftmost) of the group, the second becomes bit 1 and the third becomes bit 0. A group becomes usable on the third strobe.
- R3: Group-to-increment mapping in 45-degree units: 001→0, 000→1, 010→2, 011→3, 111→4, 110→5, 100→6, 101→7.
- R4: On each cycle with tx_sym_en high, tx_phase becomes (tx_phase + increment) mod 8, visible one clock after the strobe. Without tx_sym_en, tx_phase holds.
- R5: With train_en high at a symbol strobe, the increment is 4 whatever the pending group is.
- R6: Until the first complete group after reset, the pending group is 001, so symbol strobes leave tx_phase unchanged.
- R7: One clock after a cycle with rx_sym_en high, rx_tribit_valid is high for one cycle and rx_tribit holds the inverse-table group of (rx_phase − previous rx_phase) mod 8. rx_tribit_valid is low in every other cycle.
- R8: The first received symbol after reset is differenced against phase index 0.
- R9: The decoded group is loaded for serial output two clocks after rx_sym_en. After that, each rx_bit_en strobe presents the next bit on rx_bit, leftmost bit first, with rx_bit_valid high for one cycle one clock after the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tx_bit | input | 1 | Serial transmit data bit |
| tx_bit_en | input | 1 | Transmit bit strobe |
| tx_sym_en | input | 1 | Transmit symbol strobe |
| train_en | input | 1 | Force a half-turn increment on every symbol |
| tx_phase | output | 3 | Absolute transmit phase index, 45-degree units |
| rx_phase | input | 3 | Received absolute phase index |
| rx_sym_en | input | 1 | Receive symbol strobe |
| rx_bit_en | input | 1 | Request for the next recovered bit |
| rx_tribit | output | 3 | Decoded group |
| rx_tribit_valid | output | 1 | Decoded group valid pulse |
| rx_bit | output | 1 | Recovered serial bit |
| rx_bit_valid | output | 1 | Recovered bit valid pulse |

## Verification
The hardest state to reach from the ports is a reset that arrives while a group is half assembled. If the assembly counter survives that reset, the stale count stays hidden until a later group is misaligned. The bench sends two bits, resets, and then sends the group 111. It expects a half-turn, which only an aligned group produces. Wraparound of the accumulator and of the receive difference is reached by a long pseudo-random group sequence that runs through a transmit-to-receive loopback.

// File: rtl/dpsk8_pkg.sv
package dpsk8_pkg;
  localparam int PH_W = 3;
  localparam int GRP_W = 3;
  typedef logic [PH_W-1:0] phase_t;
  typedef logic [GRP_W-1:0] group_t;
  localparam group_t GRP_IDLE = 3'b001;
  localparam phase_t PH_HALF = 3'd4;

  function automatic phase_t group_to_step(input group_t g);
    phase_t s;
    case (g)
      3'b001: s = 3'd0;
      3'b000: s = 3'd1;
      3'b010: s = 3'd2;
      3'b011: s = 3'd3;
      3'b111: s = 3'd4;
      3'b110: s = 3'd5;
      3'b100: s = 3'd6;
      default: s = 3'd7;
    endcase
    return s;
  endfunction

  function automatic group_t step_to_group(input phase_t s);
    group_t g;
    case (s)
      3'd0: g = 3'b001;
      3'd1: g = 3'b000;
      3'd2: g = 3'b010;
      3'd3: g = 3'b011;
      3'd4: g = 3'b111;
      3'd5: g = 3'b110;
      3'd6: g = 3'b100;
      default: g = 3'b101;
    endcase
    return g;
  endfunction
endpackage

// File: rtl/dpsk8_rst_sync.sv
module dpsk8_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_s = sync_q[STAGES-1];
endmodule

// File: rtl/dpsk8_grouper.sv
module dpsk8_grouper
  import dpsk8_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   bit_in,
  input  logic   bit_en,
  output group_t group_q
);
  localparam int CNT_W = $clog2(GRP_W);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [GRP_W-2:0] part_q, part_d;
  group_t           group_d;

  always_comb begin
    cnt_d   = cnt_q;
    part_d  = part_q;
    group_d = group_q;
    if (bit_en) begin
      if (cnt_q == CNT_W'(GRP_W - 1)) begin
        group_d = {part_q, bit_in};
        cnt_d   = '0;
      end else begin
        part_d = {part_q[GRP_W-3:0], bit_in};
        cnt_d  = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      part_q  <= '0;
      group_q <= GRP_IDLE;
    end else begin
      cnt_q   <= cnt_d;
      part_q  <= part_d;
      group_q <= group_d;
    end
  end
endmodule

// File: rtl/dpsk8_phase_acc.sv
module dpsk8_phase_acc
  import dpsk8_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   sym_en,
  input  logic   train,
  input  group_t group_in,
  output phase_t phase_q
);
  phase_t inc, phase_d;

  always_comb begin
    inc     = train ? PH_HALF : group_to_step(group_in);
    phase_d = phase_q;
    if (sym_en) phase_d = phase_q + inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end
endmodule

// File: rtl/dpsk8_diff_dec.sv
module dpsk8_diff_dec
  import dpsk8_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  phase_t phase_in,
  input  logic   sym_en,
  output group_t group_q,
  output logic   valid_q
);
  phase_t prev_q, prev_d;
  group_t group_d;
  logic   valid_d;

  always_comb begin
    prev_d  = prev_q;
    group_d = group_q;
    valid_d = 1'b0;
    if (sym_en) begin
      group_d = step_to_group(phase_in - prev_q);
      prev_d  = phase_in;
      valid_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      group_q <= '0;
      valid_q <= 1'b0;
    end else begin
      prev_q  <= prev_d;
      group_q <= group_d;
      valid_q <= valid_d;
    end
  end
endmodule

// File: rtl/dpsk8_serializer.sv
module dpsk8_serializer
  import dpsk8_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  group_t load_val,
  input  logic   load_en,
  input  logic   shift_en,
  output logic   bit_q,
  output logic   bit_valid_q
);
  group_t sh_q, sh_d;
  logic   bit_d, bit_valid_d;

  always_comb begin
    sh_d        = sh_q;
    bit_d       = bit_q;
    bit_valid_d = 1'b0;
    if (load_en) begin
      sh_d = load_val;
    end else if (shift_en) begin
      bit_d       = sh_q[GRP_W-1];
      sh_d        = {sh_q[GRP_W-2:0], 1'b0};
      bit_valid_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q        <= '0;
      bit_q       <= 1'b0;
      bit_valid_q <= 1'b0;
    end else begin
      sh_q        <= sh_d;
      bit_q       <= bit_d;
      bit_valid_q <= bit_valid_d;
    end
  end
endmodule

// File: rtl/dpsk8_codec.sv
module dpsk8_codec
  import dpsk8_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_bit,
  input  logic       tx_bit_en,
  input  logic       tx_sym_en,
  input  logic       train_en,
  output logic [2:0] tx_phase,
  input  logic [2:0] rx_phase,
  input  logic       rx_sym_en,
  input  logic       rx_bit_en,
  output logic [2:0] rx_tribit,
  output logic       rx_tribit_valid,
  output logic       rx_bit,
  output logic       rx_bit_valid
);
  logic   rst_n_s;
  group_t tx_group;

  dpsk8_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_s(rst_n_s)
  );

  dpsk8_grouper u_grp (
    .clk(clk), .rst_n(rst_n_s), .bit_in(tx_bit), .bit_en(tx_bit_en),
    .group_q(tx_group)
  );

  dpsk8_phase_acc u_acc (
    .clk(clk), .rst_n(rst_n_s), .sym_en(tx_sym_en), .train(train_en),
    .group_in(tx_group), .phase_q(tx_phase)
  );

  dpsk8_diff_dec u_dec (
    .clk(clk), .rst_n(rst_n_s), .phase_in(rx_phase), .sym_en(rx_sym_en),
    .group_q(rx_tribit), .valid_q(rx_tribit_valid)
  );

  dpsk8_serializer u_ser (
    .clk(clk), .rst_n(rst_n_s), .load_val(rx_tribit),
    .load_en(rx_tribit_valid), .shift_en(rx_bit_en),
    .bit_q(rx_bit), .bit_valid_q(rx_bit_valid)
  );
endmodule

// File: rtl/dpsk8_codec_chk.sv
module dpsk8_codec_chk (
  input logic       clk,
  input logic       rst_ns,
  input logic       tx_sym_en,
  input logic       train_en,
  input logic [2:0] tx_phase,
  input logic       rx_sym_en,
  input logic       rx_bit_en,
  input logic       rx_tribit_valid,
  input logic       rx_bit_valid
);
  // R4: phase only moves on a symbol strobe
  p_phase_hold_r4: assert property (@(posedge clk) disable iff (!rst_ns)
    !tx_sym_en |=> $stable(tx_phase));

  // R5: training symbol is a half-turn
  p_train_step_r5: assert property (@(posedge clk) disable iff (!rst_ns)
    (tx_sym_en && train_en) |=> (tx_phase == 3'($past(tx_phase) + 3'd4)));

  // R7: decode valid follows each receive strobe
  p_rx_valid_r7: assert property (@(posedge clk) disable iff (!rst_ns)
    rx_sym_en |=> rx_tribit_valid);

  // R7: no decode valid without a strobe
  p_rx_quiet_r7: assert property (@(posedge clk) disable iff (!rst_ns)
    !rx_sym_en |=> !rx_tribit_valid);

  // R9: a serial bit valid needs a request one clock before
  p_bit_valid_r9: assert property (@(posedge clk) disable iff (!rst_ns)
    rx_bit_valid |-> $past(rx_bit_en));
endmodule

bind dpsk8_codec dpsk8_codec_chk u_chk (
  .clk(clk), .rst_ns(rst_n_s), .tx_sym_en(tx_sym_en), .train_en(train_en),
  .tx_phase(tx_phase), .rx_sym_en(rx_sym_en), .rx_bit_en(rx_bit_en),
  .rx_tribit_valid(rx_tribit_valid), .rx_bit_valid(rx_bit_valid)
);

// File: tb/tb_dpsk8_codec.sv
`timescale 1ns/1ps
module tb_dpsk8_codec;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_bit = 1'b0, tx_bit_en = 1'b0, tx_sym_en = 1'b0, train_en = 1'b0;
  logic [2:0] tx_phase;
  logic [2:0] rx_phase = 3'd0;
  logic       rx_sym_en = 1'b0, rx_bit_en = 1'b0;
  logic [2:0] rx_tribit;
  logic       rx_tribit_valid, rx_bit, rx_bit_valid;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [2:0] model_ph;

  always #2.5 clk = ~clk;

  dpsk8_codec dut (
    .clk(clk), .rst_n(rst_n), .tx_bit(tx_bit), .tx_bit_en(tx_bit_en),
    .tx_sym_en(tx_sym_en), .train_en(train_en), .tx_phase(tx_phase),
    .rx_phase(rx_phase), .rx_sym_en(rx_sym_en), .rx_bit_en(rx_bit_en),
    .rx_tribit(rx_tribit), .rx_tribit_valid(rx_tribit_valid),
    .rx_bit(rx_bit), .rx_bit_valid(rx_bit_valid)
  );

  function automatic logic [2:0] ref_step(input logic [2:0] g);
    case (g)
      3'b001: return 3'd0;  3'b000: return 3'd1;
      3'b010: return 3'd2;  3'b011: return 3'd3;
      3'b111: return 3'd4;  3'b110: return 3'd5;
      3'b100: return 3'd6;  default: return 3'd7;
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    model_ph = 3'd0;
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk); tx_bit = b; tx_bit_en = 1'b1;
    @(negedge clk); tx_bit_en = 1'b0;
  endtask

  task automatic send_group(input logic [2:0] g);
    send_bit(g[2]); send_bit(g[1]); send_bit(g[0]);
  endtask

  task automatic tx_symbol();
    @(negedge clk); tx_sym_en = 1'b1;
    @(negedge clk); tx_sym_en = 1'b0;
  endtask

  task automatic rx_symbol(input logic [2:0] p, input logic [2:0] exp_g, input string req);
    @(negedge clk); rx_phase = p; rx_sym_en = 1'b1;
    @(negedge clk); rx_sym_en = 1'b0;
    check({req, " decode valid"}, int'(rx_tribit_valid), 1);
    check({req, " decoded group"}, int'(rx_tribit), int'(exp_g));
    @(negedge clk);
    check({req, " valid one cycle"}, int'(rx_tribit_valid), 0);
    for (int i = 2; i >= 0; i--) begin
      @(negedge clk); rx_bit_en = 1'b1;
      @(negedge clk); rx_bit_en = 1'b0;
      check("R9 serial bit", int'(rx_bit), int'(exp_g[i]));
      check("R9 bit valid", int'(rx_bit_valid), 1);
    end
  endtask

  task automatic t_reset_state();
    do_reset();
    check("R1 tx_phase", int'(tx_phase), 0);
    check("R1 rx_tribit_valid", int'(rx_tribit_valid), 0);
    check("R1 rx_bit_valid", int'(rx_bit_valid), 0);
  endtask

  task automatic t_idle_group();
    do_reset();
    tx_symbol();
    check("R6 no group yet", int'(tx_phase), 0);
    send_bit(1'b1); send_bit(1'b1);
    tx_symbol();
    check("R6 partial group", int'(tx_phase), 0);
  endtask

  task automatic t_partial_reset();
    do_reset();
    send_bit(1'b0); send_bit(1'b0);
    do_reset();
    send_group(3'b111);
    tx_symbol();
    check("R1 counter cleared", int'(tx_phase), 4);
  endtask

  task automatic t_table_order();
    do_reset();
    for (int g = 0; g < 8; g++) begin
      send_group(3'(g));
      model_ph = model_ph + ref_step(3'(g));
      tx_symbol();
      check("R3 table step", int'(tx_phase), int'(model_ph));
    end
    send_group(3'b100);
    check("R4 hold without strobe", int'(tx_phase), int'(model_ph));
    tx_symbol();
    model_ph = model_ph + 3'd6;
    check("R2 leftmost first", int'(tx_phase), int'(model_ph));
  endtask

  task automatic t_train();
    do_reset();
    send_group(3'b000);
    train_en = 1'b1;
    for (int k = 0; k < 3; k++) begin
      tx_symbol();
      model_ph = model_ph + 3'd4;
      check("R5 training half-turn", int'(tx_phase), int'(model_ph));
    end
    train_en = 1'b0;
    tx_symbol();
    model_ph = model_ph + 3'd1;
    check("R5 data after training", int'(tx_phase), int'(model_ph));
  endtask

  task automatic t_first_rx();
    do_reset();
    rx_symbol(3'd3, 3'b011, "R8 first symbol vs 0");
    rx_symbol(3'd1, 3'b100, "R7 wrap difference");
  endtask

  task automatic t_loopback();
    logic [7:0] lfsr;
    logic [2:0] g;
    do_reset();
    lfsr = 8'hA5;
    for (int n = 0; n < 40; n++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      g = lfsr[2:0];
      send_group(g);
      tx_symbol();
      model_ph = model_ph + ref_step(g);
      check("R4 accumulate mod 8", int'(tx_phase), int'(model_ph));
      rx_symbol(tx_phase, g, "R7 loopback");
    end
  endtask

  initial begin
    model_ph = 3'd0;
    t_reset_state();
    t_idle_group();
    t_partial_reset();
    t_table_order();
    t_train();
    t_first_rx();
    t_loopback();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule